// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets an external host read and write a small bank of configuration registers over a four-wire serial link. The link has an active-low select, a serial clock, a data line into the block and a data line out of it. Every frame opens with an eight-bit command that carries a direction flag and a seven-bit register address. The data bits that follow depend on the addressed register. Some registers hold sixteen bits and take two bytes. The rest hold eight bits and take one byte. A parameter mask marks which registers are wide.

The serial pins are brought into the system clock domain through synchronizer stages. Rising serial-clock edges are then detected in that domain, so all frame logic runs on the system clock. The register contents are also visible to the rest of the chip through a parallel read port. A frame is handled by one state machine with these states: ST_IDLE (select high), ST_CMD (collecting command bits), ST_WDATA (collecting write bits), ST_RDATA (shifting read bits out) and ST_HOLD (frame complete, waiting for select to rise). The transitions are as follows:
- ST_IDLE goes to ST_CMD when select goes low.
- ST_CMD goes to ST_WDATA or ST_RDATA on the eighth command bit, depending on the flag.
- ST_WDATA and ST_RDATA go to ST_HOLD on the last bit for the register's width.
- Any state returns to ST_IDLE when select goes high.

Top module: `spi_cfg_slave`

## Requirements
- R1: The first eight bits of a frame form the command, sent most significant bit first. Command bit 7 is the direction flag and bits 6..0 are the register address.
- R2: A flag of 1 writes the addressed register. A flag of 0 reads it and leaves its contents unchanged.
- R3: Registers whose bit is set in the width mask (default 0xA5, so registers 0, 2, 5 and 7) take sixteen data bits. All other registers take eight.
- R4: Data bits travel most significant bit first, in both directions.
- R5: Data in is sampled only at rising serial-clock edges. Data out changes only after a rising edge or a select release.
- R6: A frame starts with the first rising serial-clock edge after select goes low. A new frame after select is released works normally.
- R7: Releasing select in mid-frame abandons the frame, and a partly received write leaves the register unchanged.
- R8: A write takes effect only once the last data bit for the register's width has arrived.
- R9: On a read, the register is captured at the last address bit. Its most significant bit appears on data out after the next rising edge. Data out is still low just before that edge.
- R10: Data out is held low while select is high.
- R11: An address at or above the register count reads as zero, uses eight data bits, and ignores writes.
- R12: The parallel read port returns the current register value, with zero above bit 7 for narrow registers and zero for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sel_n | input | 1 | Active-low frame select |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| cfg_rd_addr | input | 7 | Parallel read port address |
| cfg_rd_data | output | 16 | Parallel read port data |

## Verification
Every serial edge passes through two synchronizer flops and an edge-detect register before the state machine acts on it. As a result, data out and a register write follow a pin-level rising edge by three system clocks. The bench holds each serial clock phase for eight system clocks. It samples data out just before it raises the next edge, so each sample reads the value produced by the previous edge. It also flips the data-in line halfway through each high phase, which shows that sampling takes place at the rising edge and not later. Register contents are read on the parallel port only after the frame has ended and select has been high for several cycles, long after the three-clock commit delay.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CMD_W  = ADDR_W + 1;
    localparam int CNT_W  = $clog2(DATA_W) + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_HOLD
    } frame_state_t;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic sel_n_in,
    input  logic mosi_in,
    output logic sck_rise,
    output logic sel_hi,
    output logic mosi_s
);
    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] sel_p;
    logic [STAGES-1:0] mosi_p;
    logic              sck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p    <= '0;
            sel_p    <= '1;
            mosi_p   <= '0;
            sck_prev <= 1'b0;
        end else begin
            sck_p    <= {sck_p[STAGES-2:0], sck_in};
            sel_p    <= {sel_p[STAGES-2:0], sel_n_in};
            mosi_p   <= {mosi_p[STAGES-2:0], mosi_in};
            sck_prev <= sck_p[STAGES-1];
        end
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_prev;
    assign sel_hi   = sel_p[STAGES-1];
    assign mosi_s   = mosi_p[STAGES-1];
endmodule

// File: rtl/spi_cfg_regbank.sv
module spi_cfg_regbank
    import spi_cfg_pkg::*;
#(
    parameter int                  NUM_REGS  = 8,
    parameter logic [NUM_REGS-1:0] WIDE_MASK = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [DATA_W-1:0] lk_data,
    output logic              lk_wide,
    output logic              lk_mapped,
    input  logic [ADDR_W-1:0] pr_addr,
    output logic [DATA_W-1:0] pr_data
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [DATA_W-1:0] reg_val [NUM_REGS];
    logic              pr_mapped;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (WIDE_MASK[i]) begin : g_wide
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                   q <= '0;
                else if (wr_en && wr_addr == ADDR_W'(i))      q <= wr_data;
            end
            assign reg_val[i] = q;
        end else begin : g_narrow
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                   q <= '0;
                else if (wr_en && wr_addr == ADDR_W'(i))      q <= wr_data[BYTE_W-1:0];
            end
            assign reg_val[i] = {{(DATA_W-BYTE_W){1'b0}}, q};
        end
    end

    assign lk_mapped = {1'b0, lk_addr} < (ADDR_W+1)'(NUM_REGS);
    assign pr_mapped = {1'b0, pr_addr} < (ADDR_W+1)'(NUM_REGS);
    assign lk_data   = lk_mapped ? reg_val[lk_addr[IDX_W-1:0]] : '0;
    assign lk_wide   = lk_mapped && WIDE_MASK[lk_addr[IDX_W-1:0]];
    assign pr_data   = pr_mapped ? reg_val[pr_addr[IDX_W-1:0]] : '0;

    AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_addr} < (ADDR_W+1)'(NUM_REGS)));  // R11
endmodule

// File: rtl/spi_cfg_fsm.sv
module spi_cfg_fsm
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sel_hi,
    input  logic              mosi_s,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic [DATA_W-1:0] lk_data,
    input  logic              lk_wide,
    input  logic              lk_mapped,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              miso
);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] WIDE_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] NARR_LAST = CNT_W'(BYTE_W - 1);

    frame_state_t      state, nxt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] cmd_sh;
    logic [DATA_W-1:0] dat_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [ADDR_W-1:0] addr_q;
    logic              wide_q;
    logic              mapped_q;
    logic              miso_q;
    logic [CNT_W-1:0]  last_bit;
    logic              cmd_done;
    logic              data_last;

    assign last_bit  = wide_q ? WIDE_LAST : NARR_LAST;
    assign cmd_done  = (state == ST_CMD) && sck_rise && (bit_cnt == CMD_LAST);
    assign data_last = sck_rise && (bit_cnt == last_bit);
    assign lk_addr   = {cmd_sh[ADDR_W-2:0], mosi_s};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (sel_hi) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_CMD;
                ST_CMD:   if (cmd_done)  nxt = cmd_sh[ADDR_W-1] ? ST_WDATA : ST_RDATA;
                ST_WDATA: if (data_last) nxt = ST_HOLD;
                ST_RDATA: if (data_last) nxt = ST_HOLD;
                ST_HOLD:  nxt = ST_HOLD;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            cmd_sh   <= '0;
            dat_sh   <= '0;
            tx_sh    <= '0;
            addr_q   <= '0;
            wide_q   <= 1'b0;
            mapped_q <= 1'b0;
            miso_q   <= 1'b0;
        end else if (sel_hi) begin
            bit_cnt <= '0;
            cmd_sh  <= '0;
            miso_q  <= 1'b0;
        end else if (sck_rise) begin
            unique case (state)
                ST_CMD: begin
                    cmd_sh <= {cmd_sh[ADDR_W-2:0], mosi_s};
                    if (bit_cnt == CMD_LAST) begin
                        bit_cnt  <= '0;
                        addr_q   <= lk_addr;
                        wide_q   <= lk_wide;
                        mapped_q <= lk_mapped;
                        tx_sh    <= lk_wide ? lk_data
                                            : {lk_data[BYTE_W-1:0], {(DATA_W-BYTE_W){1'b0}}};
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_WDATA: begin
                    dat_sh  <= {dat_sh[DATA_W-2:0], mosi_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                ST_RDATA: begin
                    miso_q  <= tx_sh[DATA_W-1];
                    tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign wr_en   = (state == ST_WDATA) && data_last && mapped_q && !sel_hi;
    assign wr_addr = addr_q;
    assign wr_data = wide_q ? {dat_sh[DATA_W-2:0], mosi_s}
                            : {{(DATA_W-BYTE_W){1'b0}}, dat_sh[BYTE_W-2:0], mosi_s};
    assign miso    = miso_q;

    AST_MISO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hi |=> !miso_q);  // R10
    AST_MISO_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_rise && !sel_hi) |=> $stable(miso_q));  // R5
    AST_WRITE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (state == ST_HOLD));  // R8
    AST_DATA_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA || state == ST_RDATA) |-> (bit_cnt <= last_bit));  // R3
    AST_CMD_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD) |-> (bit_cnt <= CMD_LAST));  // R1
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int                  NUM_REGS    = 8,
    parameter logic [NUM_REGS-1:0] WIDE_MASK   = 8'hA5,
    parameter int                  SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sel_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [ADDR_W-1:0] cfg_rd_addr,
    output logic [DATA_W-1:0] cfg_rd_data
);
    logic              sck_rise, sel_hi, mosi_s;
    logic [ADDR_W-1:0] lk_addr, wr_addr;
    logic [DATA_W-1:0] lk_data, wr_data;
    logic              lk_wide, lk_mapped, wr_en;

    spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_in(spi_sck), .sel_n_in(spi_sel_n),
        .mosi_in(spi_mosi), .sck_rise(sck_rise), .sel_hi(sel_hi), .mosi_s(mosi_s)
    );

    spi_cfg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sel_hi(sel_hi),
        .mosi_s(mosi_s), .lk_addr(lk_addr), .lk_data(lk_data), .lk_wide(lk_wide),
        .lk_mapped(lk_mapped), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .miso(spi_miso)
    );

    spi_cfg_regbank #(.NUM_REGS(NUM_REGS), .WIDE_MASK(WIDE_MASK)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lk_addr(lk_addr), .lk_data(lk_data),
        .lk_wide(lk_wide), .lk_mapped(lk_mapped), .pr_addr(cfg_rd_addr),
        .pr_data(cfg_rd_data)
    );
endmodule

// File: tb/spi_cfg_slave_tb.sv
module spi_cfg_slave_tb;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        sck = 1'b0;
    logic        mosi = 1'b0;
    logic        miso;
    logic [6:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    spi_cfg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sel_n(sel_n), .spi_sck(sck),
        .spi_mosi(mosi), .spi_miso(miso), .cfg_rd_addr(rd_addr),
        .cfg_rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // nrise rising edges; data bits follow cmd; read bits sampled before rises 10..
    task automatic frame(input logic [7:0] cmd, input logic [15:0] wd, input int nd,
                         input int nrise, output logic [15:0] rd, output logic pre9);
        logic b;
        rd = '0; pre9 = 1'b0;
        sel_n = 1'b0;
        wait_clk(6);
        for (int k = 1; k <= nrise; k++) begin
            if (k <= 8)               b = cmd[8-k];
            else if (k - 8 <= nd)     b = wd[nd-1-(k-9)];
            else                      b = 1'b0;
            mosi = b;
            wait_clk(HALF);
            if (k == 9) pre9 = miso;
            if (k >= 10 && (k - 10) < nd) rd[nd-1-(k-10)] = miso;
            sck = 1'b1;
            wait_clk(HALF/2);
            mosi = ~b;
            wait_clk(HALF/2);
            sck = 1'b0;
        end
        wait_clk(HALF);
        sel_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic spi_write(input logic [6:0] a, input logic [15:0] d, input int nd);
        logic [15:0] r; logic p;
        frame({1'b1, a}, d, nd, 8 + nd, r, p);
    endtask

    task automatic spi_read(input logic [6:0] a, input int nd, output logic [15:0] r,
                            output logic p);
        frame({1'b0, a}, 16'h0, nd, 8 + nd + 1, r, p);
    endtask

    task automatic par_read(input logic [6:0] a, output logic [15:0] d);
        rd_addr = a;
        wait_clk(1);
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        chk("R10 miso low after reset", {15'b0, miso}, 16'h0);
        par_read(7'd0, d); chk("R12 reset value reg0", d, 16'h0);
    endtask

    task automatic t_write_wide_narrow;
        logic [15:0] d;
        spi_write(7'd0, 16'hBEEF, 16);
        par_read(7'd0, d); chk("R3 R4 wide write reg0", d, 16'hBEEF);
        spi_write(7'd1, 16'h005A, 8);
        par_read(7'd1, d); chk("R3 R12 narrow write reg1", d, 16'h005A);
        spi_write(7'd5, 16'h8001, 16);
        par_read(7'd5, d); chk("R4 msb first reg5", d, 16'h8001);
        par_read(7'd7, d); chk("R1 address decode reg7 untouched", d, 16'h0);
    endtask

    task automatic t_read;
        logic [15:0] r; logic p; logic [15:0] d;
        spi_read(7'd0, 16, r, p);
        chk("R9 miso low before first data edge", {15'b0, p}, 16'h0);
        chk("R9 R4 serial read reg0", r, 16'hBEEF);
        chk("R10 miso low after frame", {15'b0, miso}, 16'h0);
        par_read(7'd0, d); chk("R2 read leaves reg0", d, 16'hBEEF);
        spi_read(7'd1, 8, r, p);
        chk("R3 serial read narrow reg1", r, 16'h005A);
        spi_read(7'd5, 16, r, p);
        chk("R4 serial read reg5", r, 16'h8001);
    endtask

    task automatic t_abort;
        logic [15:0] r; logic p; logic [15:0] d;
        frame(8'h82, 16'hFFFF, 16, 8 + 15, r, p);
        par_read(7'd2, d); chk("R7 R8 aborted wide write reg2", d, 16'h0);
        frame(8'h81, 16'h00C3, 8, 8 + 7, r, p);
        par_read(7'd1, d); chk("R8 aborted narrow write reg1", d, 16'h005A);
        frame(8'h82, 16'h0, 0, 4, r, p);
        spi_write(7'd2, 16'h1234, 16);
        par_read(7'd2, d); chk("R6 frame after abort reg2", d, 16'h1234);
    endtask

    task automatic t_unmapped;
        logic [15:0] r; logic p; logic [15:0] d;
        spi_write(7'h40, 16'h00FF, 8);
        spi_read(7'h40, 8, r, p);
        chk("R11 unmapped reads zero", r, 16'h0);
        par_read(7'h40, d); chk("R11 R12 unmapped parallel zero", d, 16'h0);
        spi_read(7'd1, 8, r, p);
        chk("R11 unmapped write leaves reg1", r, 16'h005A);
        par_read(7'd0, d); chk("R11 unmapped write leaves reg0", d, 16'hBEEF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write_wide_narrow();
        t_read();
        t_abort();
        t_unmapped();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule